// File: doc/BRIEF.md
# Signed Element Divider

This block is a sequential divider for one element of a vector datapath. A request carries a dividend, a divisor, an element-width code and a select bit that chooses between the quotient and the remainder. Both operands are read as two's-complement numbers of the selected width. The bits above that width are ignored. The result is masked to the element width and zero-extended to 64 bits.

The block never raises an exception. Division by zero has a fixed result, and so does the one signed overflow case, the most negative value divided by −1. Both fixed results depend on the element width. The block finds these two cases on the request cycle and answers after one clock edge.

Every other request goes through a radix-2 restoring loop. The loop works on unsigned magnitudes and needs one edge per element bit. The signs are applied afterwards. The handshake is a start pulse taken while ready is high, followed by a single-cycle valid pulse.

Top module: `sdiv_elem_unit`

## Requirements
- R1: An ordinary quotient is the signed quotient of the two element-width values, truncated toward zero and masked to the element width.
- R2: An ordinary remainder equals dividend − quotient × divisor. It is zero or carries the sign of the dividend, and it is masked to the element width.
- R3: When the divisor is zero at the element width, the quotient is all ones in the element bits.
- R4: When the divisor is zero at the element width, the remainder is the dividend masked to the element width.
- R5: The most negative element value divided by −1 gives, as quotient, that same most negative value.
- R6: The most negative element value divided by −1 gives a remainder of 0.
- R7: Input bits above the element width have no effect, because operands are sign-extended from bit width−1. Result bits above the width are zero. The width code on `sew_i` is 00=8, 01=16, 10=32, 11=64.
- R8: For a zero divisor or the overflow case, `valid_o` is high after exactly one rising edge following the accepting edge.
- R9: For any other request, `valid_o` is high after exactly width+2 rising edges following the accepting edge: one edge to load, width iteration edges, and one edge for sign correction.
- R10: A request is accepted only while `ready_o` is high. `ready_o` falls after an accepting edge. A start pulse while busy changes neither the result nor its timing.
- R11: While reset is asserted, `ready_o` is 1, `valid_o` is 0 and `result_o` is 0. This also holds for a reset asserted during a division.
- R12: `valid_o` stays high for one cycle only. `ready_o` returns high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when `ready_o` is high |
| dividend_i | input | 64 | Dividend; only the low element-width bits are used |
| divisor_i | input | 64 | Divisor; only the low element-width bits are used |
| sew_i | input | 2 | Element width code: 00=8, 01=16, 10=32, 11=64 |
| rem_sel_i | input | 1 | 0 returns the quotient, 1 returns the remainder |
| ready_o | output | 1 | Idle and able to accept a request |
| valid_o | output | 1 | Single-cycle pulse marking a new result |
| result_o | output | 64 | Result, zero above the element width; held until the next result |

## Verification
A zero-divisor or overflow result is due one edge after the accepting edge. An ordinary result is due width+2 edges after it, which is 10, 18, 34 or 66 edges. The bench drives the start pulse on a falling edge and then counts rising edges until it sees `valid_o` high on a falling edge. It compares that count with the latency stored in each table row, so an early or a late result fails as clearly as a wrong value does. The checker keeps its own edge counter from the accepting edge and requires `valid_o` to appear exactly at the expected count. The busy test injects a second start mid-run and still requires the first request's 66-edge timing and value.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  // Default datapath width; element widths run from 8 up to this value.
  localparam int unsigned XLEN_DEF = 64;

  // Width of the element-width code (four codes: 8, 16, 32, 64 bits).
  localparam int unsigned SEW_W = 2;

  // Control sequence of the divider.
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10,
    ST_DONE = 2'b11
  } div_state_e;

endpackage

// File: rtl/sdiv_prep.sv
// Operand preparation: width masks, sign extension, magnitudes and
// detection of the two results that need no iteration.
module sdiv_prep
  import sdiv_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN_DEF,
  parameter int unsigned CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] dvd_i,
  input  logic [DATA_W-1:0] dvs_i,
  input  logic [SEW_W-1:0]  sew_i,
  input  logic              rem_sel_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [CNT_W-1:0]  nbits_o,
  output logic              dvd_neg_o,
  output logic              dvs_neg_o,
  output logic [DATA_W-1:0] dvd_mag_o,
  output logic [DATA_W-1:0] dvs_mag_o,
  output logic              special_o,
  output logic [DATA_W-1:0] special_res_o
);

  localparam int unsigned NUM_SEW = $clog2(DATA_W / 8) + 1;

  logic [NUM_SEW-1:0][DATA_W-1:0] mask_tab;
  logic [NUM_SEW-1:0]             dvd_sgn_tab;
  logic [NUM_SEW-1:0]             dvs_sgn_tab;

  // One mask and one sign tap for each supported element width.
  for (genvar g = 0; g < NUM_SEW; g++) begin : g_sew
    localparam int unsigned EW = 8 << g;
    assign mask_tab[g]    = DATA_W'({EW{1'b1}});
    assign dvd_sgn_tab[g] = dvd_i[EW-1];
    assign dvs_sgn_tab[g] = dvs_i[EW-1];
  end

  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] min_val;
  logic [DATA_W-1:0] dvd_lo;
  logic [DATA_W-1:0] dvs_lo;
  logic [DATA_W-1:0] dvd_sx;
  logic [DATA_W-1:0] dvs_sx;
  logic              dvd_neg;
  logic              dvs_neg;
  logic              div_zero;
  logic              ovf;

  always_comb begin
    mask    = mask_tab[sew_i];
    min_val = mask & ~(mask >> 1);
    dvd_neg = dvd_sgn_tab[sew_i];
    dvs_neg = dvs_sgn_tab[sew_i];
    dvd_lo  = dvd_i & mask;
    dvs_lo  = dvs_i & mask;
    dvd_sx  = dvd_neg ? (dvd_lo | ~mask) : dvd_lo;
    dvs_sx  = dvs_neg ? (dvs_lo | ~mask) : dvs_lo;

    div_zero = (dvs_lo == '0);
    ovf      = (dvd_lo == min_val) && (dvs_lo == mask);

    if (div_zero) begin
      special_res_o = rem_sel_i ? dvd_lo : mask;
    end else begin
      special_res_o = rem_sel_i ? '0 : min_val;
    end
  end

  assign mask_o    = mask;
  assign nbits_o   = CNT_W'(8) << sew_i;
  assign dvd_neg_o = dvd_neg;
  assign dvs_neg_o = dvs_neg;
  assign dvd_mag_o = dvd_neg ? (~dvd_sx + 1'b1) : dvd_sx;
  assign dvs_mag_o = dvs_neg ? (~dvs_sx + 1'b1) : dvs_sx;
  assign special_o = div_zero | ovf;

endmodule

// File: rtl/sdiv_core.sv
// Radix-2 restoring divider on unsigned magnitudes, one quotient bit per step.
module sdiv_core #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] dvd_mag_i,
  input  logic [DATA_W-1:0] dvs_mag_i,
  input  logic [CNT_W-1:0]  nbits_i,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              last_o
);

  logic [DATA_W-1:0] rem_q, rem_n;
  logic [DATA_W-1:0] quo_q, quo_n;
  logic [DATA_W-1:0] dvs_q, dvs_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W:0]   trial;
  logic [DATA_W-1:0] diff;
  logic              fits;
  logic              en;

  // Next state: trial subtraction of the divisor from the shifted remainder.
  always_comb begin
    trial = {rem_q, quo_q[DATA_W-1]};
    fits  = (trial >= {1'b0, dvs_q});
    diff  = trial[DATA_W-1:0] - dvs_q;
    en    = load_i | step_i;
    rem_n = rem_q;
    quo_n = quo_q;
    dvs_n = dvs_q;
    cnt_n = cnt_q;
    if (load_i) begin
      rem_n = '0;
      quo_n = dvd_mag_i << (CNT_W'(DATA_W) - nbits_i);
      dvs_n = dvs_mag_i;
      cnt_n = nbits_i;
    end else if (step_i) begin
      rem_n = fits ? diff : trial[DATA_W-1:0];
      quo_n = {quo_q[DATA_W-2:0], fits};
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (en) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      dvs_q <= dvs_n;
      cnt_q <= cnt_n;
    end
  end

  assign quo_o  = quo_q;
  assign rem_o  = rem_q;
  assign last_o = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/sdiv_fixup.sv
// Sign correction and width masking of the iterated magnitudes.
module sdiv_fixup #(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0] quo_i,
  input  logic [DATA_W-1:0] rem_i,
  input  logic              quo_neg_i,
  input  logic              rem_neg_i,
  input  logic              rem_sel_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] res_o
);

  logic [DATA_W-1:0] quo_s;
  logic [DATA_W-1:0] rem_s;

  always_comb begin
    quo_s = quo_neg_i ? (~quo_i + 1'b1) : quo_i;
    rem_s = rem_neg_i ? (~rem_i + 1'b1) : rem_i;
    res_o = (rem_sel_i ? rem_s : quo_s) & mask_i;
  end

endmodule

// File: rtl/sdiv_elem_unit.sv
// Signed element divider: quotient or remainder at 8/16/32/64-bit width.
module sdiv_elem_unit
  import sdiv_pkg::*;
#(
  parameter int unsigned DATA_W = XLEN_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic [SEW_W-1:0]  sew_i,
  input  logic              rem_sel_i,
  output logic              ready_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);

  localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

  div_state_e state_q, state_n;

  logic [DATA_W-1:0] mask;
  logic [CNT_W-1:0]  nbits;
  logic              dvd_neg;
  logic              dvs_neg;
  logic [DATA_W-1:0] dvd_mag;
  logic [DATA_W-1:0] dvs_mag;
  logic              special;
  logic [DATA_W-1:0] special_res;

  logic [DATA_W-1:0] core_quo;
  logic [DATA_W-1:0] core_rem;
  logic              core_last;
  logic              core_load;
  logic              core_step;

  logic [DATA_W-1:0] fix_res;

  logic              ctx_en;
  logic              rem_sel_q;
  logic              quo_neg_q;
  logic              rem_neg_q;
  logic [DATA_W-1:0] mask_q;

  logic              res_en;
  logic [DATA_W-1:0] result_q, result_n;

  logic              accept;

  sdiv_prep #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_prep (
    .dvd_i         (dividend_i),
    .dvs_i         (divisor_i),
    .sew_i         (sew_i),
    .rem_sel_i     (rem_sel_i),
    .mask_o        (mask),
    .nbits_o       (nbits),
    .dvd_neg_o     (dvd_neg),
    .dvs_neg_o     (dvs_neg),
    .dvd_mag_o     (dvd_mag),
    .dvs_mag_o     (dvs_mag),
    .special_o     (special),
    .special_res_o (special_res)
  );

  sdiv_core #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (core_load),
    .step_i    (core_step),
    .dvd_mag_i (dvd_mag),
    .dvs_mag_i (dvs_mag),
    .nbits_i   (nbits),
    .quo_o     (core_quo),
    .rem_o     (core_rem),
    .last_o    (core_last)
  );

  sdiv_fixup #(
    .DATA_W (DATA_W)
  ) u_fixup (
    .quo_i     (core_quo),
    .rem_i     (core_rem),
    .quo_neg_i (quo_neg_q),
    .rem_neg_i (rem_neg_q),
    .rem_sel_i (rem_sel_q),
    .mask_i    (mask_q),
    .res_o     (fix_res)
  );

  assign accept = start_i && (state_q == ST_IDLE);

  // Next-state and control decode.
  always_comb begin
    state_n   = state_q;
    core_load = 1'b0;
    core_step = 1'b0;
    ctx_en    = 1'b0;
    res_en    = 1'b0;
    result_n  = result_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          ctx_en = 1'b1;
          if (special) begin
            res_en   = 1'b1;
            result_n = special_res;
            state_n  = ST_DONE;
          end else begin
            core_load = 1'b1;
            state_n   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        core_step = 1'b1;
        if (core_last) begin
          state_n = ST_FIX;
        end
      end
      ST_FIX: begin
        res_en   = 1'b1;
        result_n = fix_res;
        state_n  = ST_DONE;
      end
      ST_DONE: begin
        state_n = ST_IDLE;
      end
      default: begin
        state_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_sel_q <= 1'b0;
      quo_neg_q <= 1'b0;
      rem_neg_q <= 1'b0;
      mask_q    <= '0;
    end else if (ctx_en) begin
      rem_sel_q <= rem_sel_i;
      quo_neg_q <= dvd_neg ^ dvs_neg;
      rem_neg_q <= dvd_neg;
      mask_q    <= mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (res_en) begin
      result_q <= result_n;
    end
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign valid_o  = (state_q == ST_DONE);
  assign result_o = result_q;

endmodule

// File: rtl/sdiv_elem_chk.sv
// Protocol and result checker for sdiv_elem_unit.
module sdiv_elem_chk #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [DATA_W-1:0] dividend_i,
  input logic [DATA_W-1:0] divisor_i,
  input logic [1:0]        sew_i,
  input logic              rem_sel_i,
  input logic              ready_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);

  logic              acc;
  logic [DATA_W-1:0] in_mask;
  logic [DATA_W-1:0] in_min;
  logic              in_dz;
  logic              in_ovf;

  logic [DATA_W-1:0] cap_mask;
  logic [DATA_W-1:0] cap_min;
  logic [DATA_W-1:0] cap_dvd;
  logic              cap_rem;
  logic              cap_dz;
  logic              cap_ovf;
  logic [7:0]        exp_lat;
  logic [7:0]        lat_cnt;

  assign acc = start_i && ready_o;

  always_comb begin
    case (sew_i)
      2'b00:   in_mask = DATA_W'(8'hFF);
      2'b01:   in_mask = DATA_W'(16'hFFFF);
      2'b10:   in_mask = DATA_W'(32'hFFFF_FFFF);
      default: in_mask = {DATA_W{1'b1}};
    endcase
    in_min = in_mask ^ (in_mask >> 1);
    in_dz  = (divisor_i & in_mask) == '0;
    in_ovf = ((dividend_i & in_mask) == in_min) && ((divisor_i & in_mask) == in_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_mask <= '0;
      cap_min  <= '0;
      cap_dvd  <= '0;
      cap_rem  <= 1'b0;
      cap_dz   <= 1'b0;
      cap_ovf  <= 1'b0;
      exp_lat  <= '0;
      lat_cnt  <= '0;
    end else begin
      if (acc) begin
        cap_mask <= in_mask;
        cap_min  <= in_min;
        cap_dvd  <= dividend_i & in_mask;
        cap_rem  <= rem_sel_i;
        cap_dz   <= in_dz;
        cap_ovf  <= in_ovf;
        exp_lat  <= (in_dz || in_ovf) ? 8'd1 : (8'd8 << sew_i) + 8'd2;
        lat_cnt  <= 8'd1;
      end else if (valid_o) begin
        lat_cnt <= '0;
      end else if (lat_cnt != '0) begin
        lat_cnt <= lat_cnt + 8'd1;
      end
    end
  end

  // R12
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> (!valid_o && ready_o));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> !ready_o);

  // R8
  special_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && (cap_dz || cap_ovf)) |-> (lat_cnt == 8'd1));

  // R9
  iter_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (lat_cnt == exp_lat));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((result_o & ~cap_mask) == '0));

  // R3
  dz_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cap_dz && !cap_rem) |-> (result_o == cap_mask));

  // R4
  dz_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cap_dz && cap_rem) |-> (result_o == cap_dvd));

  // R5
  ovf_quo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cap_ovf && !cap_rem) |-> (result_o == cap_min));

  // R6
  ovf_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cap_ovf && cap_rem) |-> (result_o == '0));

  // R2
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cap_rem && !cap_dz && !cap_ovf && (result_o != '0))
      |-> (((result_o & cap_min) != '0) == ((cap_dvd & cap_min) != '0)));

endmodule

bind sdiv_elem_unit sdiv_elem_chk #(
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .dividend_i (dividend_i),
  .divisor_i  (divisor_i),
  .sew_i      (sew_i),
  .rem_sel_i  (rem_sel_i),
  .ready_o    (ready_o),
  .valid_o    (valid_o),
  .result_o   (result_o)
);

// File: tb/sdiv_elem_unit_tb.sv
`timescale 1ns/1ps
module sdiv_elem_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [63:0] dividend_i;
  logic [63:0] divisor_i;
  logic [1:0]  sew_i;
  logic        rem_sel_i;
  logic        ready_o;
  logic        valid_o;
  logic [63:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  sdiv_elem_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .sew_i      (sew_i),
    .rem_sel_i  (rem_sel_i),
    .ready_o    (ready_o),
    .valid_o    (valid_o),
    .result_o   (result_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Row: {sew code, remainder select, dividend, divisor, expected result, latency}
  localparam int NV = 18;
  localparam logic [202:0] VEC [NV] = '{
    {2'b00, 1'b0, 64'h07, 64'hFE, 64'hFD, 8'd10},
    {2'b00, 1'b1, 64'h07, 64'hFE, 64'h01, 8'd10},
    {2'b00, 1'b1, 64'hF9, 64'h02, 64'hFF, 8'd10},
    {2'b00, 1'b0, 64'hF9, 64'h02, 64'hFD, 8'd10},
    {2'b01, 1'b0, 64'hDEAD_BEEF_0000_0064, 64'h1234_0000_0000_0007, 64'h000E, 8'd18},
    {2'b01, 1'b1, 64'hDEAD_BEEF_0000_0064, 64'h1234_0000_0000_0007, 64'h0002, 8'd18},
    {2'b10, 1'b0, 64'h8000_0000, 64'hFFFF_FFFF, 64'h8000_0000, 8'd1},
    {2'b10, 1'b1, 64'h8000_0000, 64'hFFFF_FFFF, 64'h0, 8'd1},
    {2'b11, 1'b0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 8'd1},
    {2'b00, 1'b0, 64'h35, 64'h100, 64'hFF, 8'd1},
    {2'b11, 1'b0, 64'h5, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 8'd1},
    {2'b01, 1'b1, 64'hABCD_0000_0000_9876, 64'h0, 64'h9876, 8'd1},
    {2'b11, 1'b0, 64'hFFFF_FFFF_FFFF_FF9C, 64'hFFFF_FFFF_FFFF_FFF9, 64'hE, 8'd66},
    {2'b11, 1'b1, 64'hFFFF_FFFF_FFFF_FF9C, 64'hFFFF_FFFF_FFFF_FFF9, 64'hFFFF_FFFF_FFFF_FFFE, 8'd66},
    {2'b10, 1'b0, 64'h7FFF_FFFF, 64'h1, 64'h7FFF_FFFF, 8'd34},
    {2'b00, 1'b0, 64'h80, 64'h02, 64'hC0, 8'd10},
    {2'b00, 1'b1, 64'h80, 64'h03, 64'hFE, 8'd10},
    {2'b10, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_0000_0001, 64'h8000_0000, 8'd34}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 3, 12, 14, 15: vec_tag = "R1";
      1, 2, 13, 16:     vec_tag = "R2";
      4, 5, 17:         vec_tag = "R7";
      6, 8:             vec_tag = "R5";
      7:                vec_tag = "R6";
      9, 10:            vec_tag = "R3";
      default:          vec_tag = "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request on a falling edge; return the result and the number
  // of rising edges from the accepting edge until valid_o is seen.
  task automatic run_op(input logic [1:0] sew, input logic rsel,
                        input logic [63:0] dvd, input logic [63:0] dvs,
                        output logic [63:0] res, output int lat);
    @(negedge clk);
    start_i    = 1'b1;
    sew_i      = sew;
    rem_sel_i  = rsel;
    dividend_i = dvd;
    divisor_i  = dvs;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!valid_o && lat < 300) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    res = result_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] res;
    int          lat;

    rst_n      = 1'b0;
    start_i    = 1'b0;
    dividend_i = '0;
    divisor_i  = '0;
    sew_i      = '0;
    rem_sel_i  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 ready", 64'(ready_o), 64'd1);
    chk("R11 valid", 64'(valid_o), 64'd0);
    chk("R11 result", result_o, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][202:201], VEC[i][200], VEC[i][199:136], VEC[i][135:72], res, lat);
      chk(vec_tag(i), res, VEC[i][71:8]);
      // R8 for one-edge rows, R9 for iterated rows
      chk((VEC[i][7:0] == 8'd1) ? "R8 latency" : "R9 latency", 64'(lat), 64'(VEC[i][7:0]));
      @(negedge clk);
      // R12 valid pulse ends, ready returns
      chk("R12 valid", 64'(valid_o), 64'd0);
      chk("R12 ready", 64'(ready_o), 64'd1);
    end

    // R10: start while busy is ignored
    @(negedge clk);
    start_i    = 1'b1;
    sew_i      = 2'b11;
    rem_sel_i  = 1'b0;
    dividend_i = 64'd1000;
    divisor_i  = 64'd10;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    chk("R10 ready low", 64'(ready_o), 64'd0);
    repeat (2) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    start_i    = 1'b1;
    sew_i      = 2'b00;
    rem_sel_i  = 1'b1;
    dividend_i = 64'h5;
    divisor_i  = 64'h0;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat++;
    while (!valid_o && lat < 300) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    chk("R10 result", result_o, 64'd100);
    chk("R10 latency", 64'(lat), 64'd66);
    @(negedge clk);
    chk("R10 no second result", 64'(valid_o), 64'd0);

    // R11: reset in the middle of a division
    @(negedge clk);
    start_i    = 1'b1;
    sew_i      = 2'b10;
    rem_sel_i  = 1'b0;
    dividend_i = 64'd77;
    divisor_i  = 64'd7;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 mid ready", 64'(ready_o), 64'd1);
    chk("R11 mid valid", 64'(valid_o), 64'd0);
    chk("R11 mid result", result_o, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_op(2'b10, 1'b0, 64'd77, 64'd7, res, lat);
    chk("R1 after reset", res, 64'd11);
    chk("R9 after reset", 64'(lat), 64'd34);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule